// File: doc/BRIEF.md
# Power-Mode Startup Sequencer

The block takes a device from power-on to its full operating mode. While the supply-good comparator reports a bad supply, the device is held inactive. Once the supply is good, the block waits a fixed settling time and then parks the device in sleep. Two mode-select pins are pulled up by default. When the second pin is pulled low, the block starts the wake transition. On entry to that transition it issues a one-cycle pulse that returns the configuration registers to their defaults. When the transition ends, the block raises a reset-done status flag and pulls the active-low interrupt pin.

Software sees a 16-bit status word that is cleared by writing ones, together with an interrupt-enable register. The reset-done flag sits in the top bit. It cannot be masked, and it keeps the interrupt pin low until software writes a one to that bit. The other status bits come from generic event inputs.

All delays are counted in clock cycles and set by parameters. The supply-good flag is taken as synchronous to the clock. The mode pins are resynchronised inside the block. The register write strobes are single-cycle and are always accepted, so the block has no flow control at its edge.

Top module: `pwr_startup_seq`

## Requirements
- R1: While `supply_ok` is low at a clock edge, that edge puts `pwr_state` to OFF (code 0), clears `stat_word` and the enable register, and leaves `irq_n` high. This holds from any state.
- R2: When `supply_ok` is high in OFF, the next edge enters HOLD (code 1). HOLD lasts exactly `POR_CYC` cycles, then the block enters SLEEP (code 2). SLEEP is therefore reached `POR_CYC`+1 edges after `supply_ok` is first sampled high.
- R3: Both mode pins pass through a two-flop synchroniser that resets to 1. In SLEEP, a low `mode_b_pin` starts the wake transition (code 3) on the third edge after it changes. While `mode_b_pin` stays high, the block stays in SLEEP.
- R4: WAKE lasts exactly `WAKE_CYC` cycles and then enters RUN (code 4). RUN is reached `WAKE_CYC`+3 edges after `mode_b_pin` falls.
- R5: `cfg_defaults` is high for exactly one cycle, the first cycle of WAKE. During that cycle it clears `stat_word` and the enable register.
- R6: The edge that enters RUN sets status bit 15 (reset-done) from 0 to 1 and drives `irq_n` low.
- R7: A write with `stat_wr_en` clears each status bit whose `stat_wr_data` bit is 1. Bits written with 0 are unchanged. Bit 15 is cleared only by a write with bit 15 set.
- R8: Bit 15 of the enable register always reads as 0 internally and has no effect. `irq_n` is low whenever status bit 15 is 1.
- R9: `irq_n` = NOT(status[15] OR any(status[14:0] AND enable[14:0])). The enable register is loaded with `irq_en_data` on an `irq_en_wr` edge.
- R10: In RUN, `evt_set[14:0]` sets the matching status bits, and a set wins over a clear written in the same cycle. `evt_set[15]` is ignored. Events outside RUN are ignored.
- R11: In RUN, when both synchronised mode pins are high, the block returns to SLEEP on the third edge after the pins change. The status word is kept.
- R12: A low `rst_n` forces OFF at once and clears all state, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good comparator flag, synchronous |
| mode_a_pin | input | 1 | First mode-select pin, pulled high |
| mode_b_pin | input | 1 | Second mode-select pin; low requests wake |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | STAT_W | Write-one-to-clear data |
| irq_en_wr | input | 1 | Enable register write strobe |
| irq_en_data | input | STAT_W | Enable register data |
| evt_set | input | STAT_W | Generic status set pulses |
| pwr_state | output | 3 | 0 OFF, 1 HOLD, 2 SLEEP, 3 WAKE, 4 RUN |
| cfg_defaults | output | 1 | One-cycle register-default pulse |
| stat_word | output | STAT_W | Status register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong sequencer state appears at `pwr_state` one edge later. An off-by-one in a delay counter moves the SLEEP or RUN edge by one or more cycles, and the bench measures those edges exactly. A corrupted status or enable register shows on `stat_word` in the cycle after the faulty write. A lost unmaskable path shows as `irq_n` staying high while bit 15 reads as 1, and the checker flags that in the same cycle.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    PS_OFF   = 3'd0,
    PS_HOLD  = 3'd1,
    PS_SLEEP = 3'd2,
    PS_WAKE  = 3'd3,
    PS_RUN   = 3'd4
  } pstate_e;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '1;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
#(
  parameter int POR_CYC  = 50,
  parameter int WAKE_CYC = 30
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    supply_ok,
  input  logic    mode_a,
  input  logic    mode_b,
  output pstate_e state,
  output logic    cfg_pulse,
  output logic    rdone_set
);
  localparam int MAXC = (POR_CYC > WAKE_CYC) ? POR_CYC : WAKE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] POR_LAST  = CW'(POR_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);

  pstate_e       nxt;
  logic [CW-1:0] cnt;
  logic          go_wake;

  always_comb begin
    nxt       = state;
    go_wake   = 1'b0;
    rdone_set = 1'b0;
    if (!supply_ok) begin
      nxt = PS_OFF;
    end else begin
      case (state)
        PS_OFF:   nxt = PS_HOLD;
        PS_HOLD:  if (cnt == POR_LAST) nxt = PS_SLEEP;
        PS_SLEEP: if (!mode_b) begin
                    nxt     = PS_WAKE;
                    go_wake = 1'b1;
                  end
        PS_WAKE:  if (cnt == WAKE_LAST) begin
                    nxt       = PS_RUN;
                    rdone_set = 1'b1;
                  end
        PS_RUN:   if (mode_a && mode_b) nxt = PS_SLEEP;
        default:  nxt = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_OFF;
      cnt       <= '0;
      cfg_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      cfg_pulse <= go_wake;
      if (nxt != state) cnt <= '0;
      else if (state == PS_HOLD || state == PS_WAKE) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pss_status.sv
module pss_status #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              accept_evt,
  input  logic              rdone_set,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              ie_wr,
  input  logic [STAT_W-1:0] ie_data,
  input  logic [STAT_W-1:0] evt,
  output logic [STAT_W-1:0] status,
  output logic              irq_n
);
  localparam int RDONE = STAT_W - 1;
  localparam logic [STAT_W-1:0] LOW_MASK = {1'b0, {(STAT_W-1){1'b1}}};

  logic [STAT_W-1:0] ie_q;
  logic [STAT_W-1:0] nxt;

  always_comb begin
    nxt = status;
    if (wr_en) nxt = nxt & ~wr_data;
    if (accept_evt) nxt = nxt | (evt & LOW_MASK);
    if (rdone_set) nxt[RDONE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      ie_q   <= '0;
    end else if (clr) begin
      status <= '0;
      ie_q   <= '0;
    end else begin
      status <= nxt;
      if (ie_wr) ie_q <= ie_data & LOW_MASK;
    end
  end

  assign irq_n = ~(status[RDONE] | (|(status & ie_q)));
endmodule

// File: rtl/pwr_startup_seq.sv
module pwr_startup_seq
  import pss_pkg::*;
#(
  parameter int POR_CYC  = 50,
  parameter int WAKE_CYC = 30,
  parameter int STAT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              mode_a_pin,
  input  logic              mode_b_pin,
  input  logic              stat_wr_en,
  input  logic [STAT_W-1:0] stat_wr_data,
  input  logic              irq_en_wr,
  input  logic [STAT_W-1:0] irq_en_data,
  input  logic [STAT_W-1:0] evt_set,
  output logic [2:0]        pwr_state,
  output logic              cfg_defaults,
  output logic [STAT_W-1:0] stat_word,
  output logic              irq_n
);
  logic [1:0] pins_s;
  pstate_e    st;
  logic       rdone_set;
  logic       clr_all;

  pss_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({mode_a_pin, mode_b_pin}), .q(pins_s)
  );

  pss_fsm #(.POR_CYC(POR_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .mode_a(pins_s[1]), .mode_b(pins_s[0]),
    .state(st), .cfg_pulse(cfg_defaults), .rdone_set(rdone_set)
  );

  assign clr_all = !supply_ok || st == PS_OFF || st == PS_HOLD || cfg_defaults;

  pss_status #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .accept_evt(st == PS_RUN), .rdone_set(rdone_set),
    .wr_en(stat_wr_en), .wr_data(stat_wr_data),
    .ie_wr(irq_en_wr), .ie_data(irq_en_data), .evt(evt_set),
    .status(stat_word), .irq_n(irq_n)
  );

  assign pwr_state = st;
endmodule

// File: rtl/pss_chk.sv
module pss_chk #(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              stat_wr_en,
  input logic [STAT_W-1:0] stat_wr_data,
  input logic [2:0]        pwr_state,
  input logic              cfg_defaults,
  input logic [STAT_W-1:0] stat_word,
  input logic              irq_n
);
  localparam int RD = STAT_W - 1;

  p_off_nosupply_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (pwr_state == 3'd0 && stat_word == '0 && irq_n));

  p_wake_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3 && supply_ok) |=> (pwr_state == 3'd3 || pwr_state == 3'd4));

  p_cfg_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_defaults |=> !cfg_defaults);

  p_cfg_pulse_in_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_defaults |-> pwr_state == 3'd3);

  p_run_sets_rdone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_state == 3'd4) |-> stat_word[RD]);

  p_rdone_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[RD] && supply_ok && !cfg_defaults && !(stat_wr_en && stat_wr_data[RD]))
      |=> stat_word[RD]);

  p_rdone_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[RD] |-> !irq_n);

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word == '0) |-> irq_n);
endmodule

bind pwr_startup_seq pss_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
  .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
  .pwr_state(pwr_state), .cfg_defaults(cfg_defaults),
  .stat_word(stat_word), .irq_n(irq_n)
);

// File: tb/tb_pwr_startup_seq.sv
module tb_pwr_startup_seq;
  localparam int POR  = 50;
  localparam int WAKE = 30;
  localparam int W    = 16;

  logic clk = 0, rst_n = 0, supply_ok = 0, mode_a_pin = 1, mode_b_pin = 1;
  logic stat_wr_en = 0, irq_en_wr = 0;
  logic [W-1:0] stat_wr_data = '0, irq_en_data = '0, evt_set = '0;
  logic [2:0] pwr_state;
  logic cfg_defaults, irq_n;
  logic [W-1:0] stat_word;

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    logic [2:0]  st;
    logic        irq;
    logic [15:0] sts;
  } item_t;
  item_t exp_q[$];

  pwr_startup_seq #(.POR_CYC(POR), .WAKE_CYC(WAKE), .STAT_W(W)) dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [2:0] s, input logic i, input logic [15:0] v);
    item_t it;
    it.tag = tag; it.st = s; it.irq = i; it.sts = v;
    exp_q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (pwr_state !== it.st || irq_n !== it.irq || stat_word !== it.sts) begin
          fails++;
          $display("FAIL %s actual st=%0d irq_n=%0b stat=%h expected st=%0d irq_n=%0b stat=%h",
                   it.tag, pwr_state, irq_n, stat_word, it.st, it.irq, it.sts);
        end
      end
    end
  end

  task automatic wait_state(input logic [2:0] s, input int lim,
                            output int n, output int pulse_at, output int pulses);
    n = 0; pulse_at = -1; pulses = 0;
    while (n < lim) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (cfg_defaults) begin pulses++; pulse_at = n; end
      if (pwr_state == s) break;
    end
  endtask

  task automatic wr_stat(input logic [W-1:0] d);
    @(negedge clk); stat_wr_en = 1; stat_wr_data = d;
    @(negedge clk); stat_wr_en = 0; stat_wr_data = '0;
  endtask

  task automatic wr_ie(input logic [W-1:0] d);
    @(negedge clk); irq_en_wr = 1; irq_en_data = d;
    @(negedge clk); irq_en_wr = 0;
  endtask

  task automatic pulse_evt(input logic [W-1:0] d);
    @(negedge clk); evt_set = d;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : driver
    int n, pa, pc;
    repeat (2) @(negedge clk);
    push("R12 reset state", 3'd0, 1'b1, 16'h0);
    chk("R12 cfg_defaults low in reset", cfg_defaults, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    push("R1 stays OFF without supply", 3'd0, 1'b1, 16'h0);

    // R2: power-on settling delay
    @(negedge clk); supply_ok = 1;
    @(negedge clk);
    push("R2 HOLD after supply good", 3'd1, 1'b1, 16'h0);
    wait_state(3'd2, 200, n, pa, pc);
    chk("R2 edges to SLEEP", n + 1, POR + 1);

    // R3: sleep held while pin high
    repeat (10) @(negedge clk);
    push("R3 SLEEP while mode_b high", 3'd2, 1'b1, 16'h0);

    // R4/R5/R6: wake
    mode_b_pin = 0;
    wait_state(3'd4, 200, n, pa, pc);
    chk("R4 edges to RUN", n, WAKE + 3);
    chk("R5 pulse count", pc, 1);
    chk("R3 R5 pulse on third edge", pa, 3);
    push("R6 reset-done set, irq low", 3'd4, 1'b0, 16'h8000);

    // R8: enabling bit 15 is ignored, and masking everything leaves irq low
    wr_ie(16'h0000);
    push("R8 unmaskable with enables off", 3'd4, 1'b0, 16'h8000);
    // R7: zeros leave bits, bit 15 needs a one
    wr_stat(16'h7FFF);
    push("R7 write without bit 15 keeps it", 3'd4, 1'b0, 16'h8000);
    wr_stat(16'h8000);
    push("R7 write bit 15 clears", 3'd4, 1'b1, 16'h0000);

    // R10: events, bit 15 ignored
    pulse_evt(16'h8003);
    push("R10 events set low bits only", 3'd4, 1'b1, 16'h0003);
    wr_ie(16'h8000);
    push("R8 enable bit 15 has no effect", 3'd4, 1'b1, 16'h0003);
    wr_ie(16'h0002);
    push("R9 enabled pending drives irq", 3'd4, 1'b0, 16'h0003);
    wr_stat(16'h0002);
    push("R9 R7 clear enabled bit", 3'd4, 1'b1, 16'h0001);
    @(negedge clk); evt_set = 16'h0001; stat_wr_en = 1; stat_wr_data = 16'h0001;
    @(negedge clk); evt_set = '0; stat_wr_en = 0; stat_wr_data = '0;
    push("R10 set wins over clear", 3'd4, 1'b1, 16'h0001);

    // R11: back to sleep
    mode_b_pin = 1;
    wait_state(3'd2, 50, n, pa, pc);
    chk("R11 edges to SLEEP", n, 3);
    push("R11 status kept in SLEEP", 3'd2, 1'b1, 16'h0001);
    pulse_evt(16'h0004);
    push("R10 events ignored in SLEEP", 3'd2, 1'b1, 16'h0001);

    // R5: second wake clears status and enables
    wr_ie(16'h0002);
    mode_b_pin = 0;
    wait_state(3'd4, 200, n, pa, pc);
    chk("R5 second wake pulse count", pc, 1);
    push("R5 status cleared then reset-done", 3'd4, 1'b0, 16'h8000);
    pulse_evt(16'h0002);
    wr_stat(16'h8000);
    push("R5 enables cleared by pulse", 3'd4, 1'b1, 16'h0002);

    // R1: supply loss
    @(negedge clk); supply_ok = 0;
    @(negedge clk);
    push("R1 OFF after supply loss", 3'd0, 1'b1, 16'h0000);

    // R12: async reset mid-HOLD
    @(negedge clk); supply_ok = 1;
    repeat (5) @(negedge clk);
    push("R2 HOLD again", 3'd1, 1'b1, 16'h0000);
    @(posedge clk); #1 rst_n = 0;
    #0.5;
    chk("R12 async OFF", pwr_state, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule